// File: doc/BRIEF.md
# Field-Slot Frame Gate Controller

This block decides, one field at a time, whether the windowed horizontal reference of a video source reaches the capture logic downstream. A strobe at the start of each field, together with the odd-field flag, the scan mode (interlaced or progressive), a 2-bit field-mode setting, a one-hot slot divider and a single-frame request bit, sets a per-field enable. The enable is then held until the next field start. The gated reference is the windowed reference ANDed with that enable.

In interlaced scan, the field mode selects no fields, odd fields only, even fields only, or every field. In progressive scan, the two middle codes select slot mode instead. In slot mode a counter that advances on every field start opens one field out of every 2, 4, 8, 16, 32 or 64. When the field mode is off, a single-frame request opens exactly one odd field and the even field that follows it. The block then returns a one-cycle clear pulse to the register that holds the request.

Top module: `field_gate_ctrl`

## Requirements
- R1: After reset, href_o, field_en_o and single_clr_o are all 0.
- R2: The field enable changes only on a cycle where field_start_i is 1. Changes to the mode inputs between field starts leave href_o unchanged until the next field start.
- R3: In interlaced scan (progressive_i=0), field_mode_i 2'b00 gates every field off, 2'b01 passes odd fields only (odd_field_i=1), 2'b10 passes even fields only, and 2'b11 passes every field.
- R4: In progressive scan, field_mode_i 2'b11 passes every field whatever the value of slot_sel_i.
- R5: In progressive scan with field_mode_i 2'b01 or 2'b10, one field in every 2^(k+1) is passed, where k is the set bit of slot_sel_i (bit 0 gives 2, bit 5 gives 64). The first field after reset is a passed field.
- R6: A slot_sel_i value that does not have exactly one bit set, zero included, acts as divide-by-2.
- R7: With field_mode_i 2'b00 and single_req_i=1, exactly two consecutive fields are passed, starting with an odd field. No field after them is passed.
- R8: A single-frame request that is raised during or before an even field start waits until the next odd field start.
- R9: single_clr_o is a one-cycle pulse. It appears in the cycle after the field start that ends the captured pair.
- R10: Dropping single_req_i after the capture has begun does not cut off the second field, and the clear pulse is still issued.
- R11: When field_mode_i is not 2'b00, single_req_i has no effect: gating follows the mode and no clear pulse is issued.
- R12: href_o is 0 whenever href_win_i is 0, even in an enabled field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel-domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | One-cycle strobe at the start of each field |
| odd_field_i | input | 1 | 1 for an odd field, sampled with field_start_i |
| progressive_i | input | 1 | 1 selects progressive scan, 0 selects interlaced |
| slot_sel_i | input | SLOT_W (6) | One-hot slot divider |
| field_mode_i | input | 2 | Field mode code |
| single_req_i | input | 1 | Single-frame request bit |
| href_win_i | input | 1 | Windowed horizontal reference |
| href_o | output | 1 | Gated horizontal reference |
| field_en_o | output | 1 | Enable held for the current field |
| single_clr_o | output | 1 | Clear pulse to the single-frame request bit |

## Verification
The hardest case to reach is the 64-field slot period. The bench drives 65 field-start strobes after a reset, so the counter starts at a known phase, and then checks that only the first and the last of those fields open. The single-frame sequence needs a similar setup. The bench raises the request during an even field, then drops it between the two fields of the pair, and models the request register by clearing the bit when it sees the pulse. This lets it check that the pair is not cut short, that the capture waits for the odd field, and that no third field opens.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic [1:0] {
    SHOT_IDLE   = 2'd0,
    SHOT_FIRST  = 2'd1,
    SHOT_SECOND = 2'd2
  } shot_state_e;

  typedef enum logic [1:0] {
    FM_OFF  = 2'b00,
    FM_ODD  = 2'b01,
    FM_EVEN = 2'b10,
    FM_ALL  = 2'b11
  } field_mode_e;
endpackage

// File: rtl/fgc_slot_div.sv
module fgc_slot_div #(
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  output logic              hit_o
);
  localparam int CNT_W = SLOT_W;

  logic [CNT_W-1:0] mask [SLOT_W];
  logic [CNT_W-1:0] mask_or;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] cnt_q;

  for (genvar k = 0; k < SLOT_W; k++) begin : g_mask
    localparam logic [CNT_W-1:0] LastIdx = CNT_W'((2 ** (k + 1)) - 1);
    assign mask[k] = slot_sel_i[k] ? LastIdx : '0;
  end

  always_comb begin
    mask_or = '0;
    for (int k = 0; k < SLOT_W; k++) mask_or = mask_or | mask[k];
    // non-one-hot falls back to divide-by-2
    period_m1 = $onehot(slot_sel_i) ? mask_or : CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (adv_i) begin
      if (cnt_q >= period_m1) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hit_o = (cnt_q == '0);

  a_r6_invalid_div2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !$onehot(slot_sel_i) && hit_o |=> !hit_o);

  a_r5_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/fgc_single_shot.sv
module fgc_single_shot
  import fgc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic odd_i,
  input  logic arm_ok_i,
  input  logic req_i,
  output logic en_o,
  output logic done_o
);
  shot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    en_o    = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      SHOT_IDLE: begin
        if (arm_ok_i && req_i && odd_i) begin
          en_o    = 1'b1;
          state_d = SHOT_FIRST;
        end
      end
      SHOT_FIRST: begin
        en_o    = 1'b1;
        state_d = SHOT_SECOND;
      end
      SHOT_SECOND: begin
        done_o  = 1'b1;
        state_d = SHOT_IDLE;
      end
      default: state_d = SHOT_IDLE;
    endcase
    if (!adv_i) begin
      state_d = state_q;
      en_o    = 1'b0;
      done_o  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SHOT_IDLE;
    else         state_q <= state_d;
  end

  a_r8_start_on_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == SHOT_FIRST) |-> $past(odd_i));

  a_r7_pair_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SHOT_FIRST && adv_i |=> state_q == SHOT_SECOND);
endmodule

// File: rtl/field_gate_ctrl.sv
module field_gate_ctrl
  import fgc_pkg::*;
#(
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              field_start_i,
  input  logic              odd_field_i,
  input  logic              progressive_i,
  input  logic [SLOT_W-1:0] slot_sel_i,
  input  logic [1:0]        field_mode_i,
  input  logic              single_req_i,
  input  logic              href_win_i,
  output logic              href_o,
  output logic              field_en_o,
  output logic              single_clr_o
);
  logic slot_hit, shot_en, shot_done, en_d;
  logic field_en_q, clr_q;
  field_mode_e mode;

  assign mode = field_mode_e'(field_mode_i);

  fgc_slot_div #(.SLOT_W(SLOT_W)) u_slot_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (field_start_i),
    .slot_sel_i (slot_sel_i),
    .hit_o      (slot_hit)
  );

  fgc_single_shot u_single_shot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (field_start_i),
    .odd_i    (odd_field_i),
    .arm_ok_i (mode == FM_OFF),
    .req_i    (single_req_i),
    .en_o     (shot_en),
    .done_o   (shot_done)
  );

  always_comb begin
    unique case (mode)
      FM_OFF:  en_d = shot_en;
      FM_ODD:  en_d = progressive_i ? slot_hit : odd_field_i;
      FM_EVEN: en_d = progressive_i ? slot_hit : !odd_field_i;
      FM_ALL:  en_d = 1'b1;
      default: en_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_en_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      if (field_start_i) field_en_q <= en_d;
      clr_q <= shot_done;
    end
  end

  assign field_en_o   = field_en_q;
  assign href_o       = href_win_i & field_en_q;
  assign single_clr_o = clr_q;

  a_r2_hold_in_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(field_en_o));

  a_r9_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_clr_o |=> !single_clr_o);

  a_r9_clr_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_clr_o |-> $past(field_start_i));

  a_r3_odd_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i && !progressive_i && field_mode_i == 2'b01 |=> field_en_o == $past(odd_field_i));

  a_r11_no_clr_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i && field_mode_i != 2'b00 && $past(field_mode_i) != 2'b00 && !field_en_o |=> !single_clr_o);

  a_r12_window_and: assert property (@(posedge clk_i) disable iff (!rst_ni)
    href_o |-> href_win_i && field_en_o);
endmodule

// File: tb/field_gate_ctrl_bench.sv
module field_gate_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_start = 1'b0, odd_field = 1'b0, progressive = 1'b0;
  logic [5:0] slot_sel = 6'b000001;
  logic [1:0] field_mode = 2'b00;
  logic single_req = 1'b0, href_win = 1'b1;
  logic href, field_en, single_clr;
  logic clr_seen;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  field_gate_ctrl u_field_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .field_start_i(field_start), .odd_field_i(odd_field),
    .progressive_i(progressive), .slot_sel_i(slot_sel), .field_mode_i(field_mode),
    .single_req_i(single_req), .href_win_i(href_win), .href_o(href),
    .field_en_o(field_en), .single_clr_o(single_clr)
  );

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    field_start = 1'b0;
    single_req = 1'b0;
    href_win = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one field: strobe, then a few idle cycles; clr_seen captures the pulse cycle
  task automatic field(input logic odd);
    @(negedge clk);
    field_start = 1'b1;
    odd_field = odd;
    @(negedge clk);
    field_start = 1'b0;
    clr_seen = single_clr;
    if (single_clr) single_req = 1'b0;
    @(negedge clk);
    check(single_clr, 0, "R9 pulse width");
  endtask

  task automatic t_reset();
    reset_dut();
    check(href, 0, "R1 href");
    check(field_en, 0, "R1 enable");
    check(single_clr, 0, "R1 clr");
  endtask

  task automatic t_interlace();
    for (int m = 0; m < 4; m++) begin
      reset_dut();
      progressive = 1'b0;
      field_mode = 2'(m);
      for (int f = 0; f < 4; f++) begin
        automatic logic odd = (f % 2 == 0);
        automatic int exp = (m == 3) ? 1 : (m == 1) ? int'(odd) : (m == 2) ? int'(!odd) : 0;
        field(odd);
        check(href, exp, "R3 interlace mode");
      end
    end
  endtask

  task automatic t_hold();
    reset_dut();
    progressive = 1'b0;
    field_mode = 2'b01;
    field(1'b1);
    check(href, 1, "R2 odd open");
    field_mode = 2'b10;
    repeat (3) @(negedge clk);
    check(href, 1, "R2 held after mode change");
    field_mode = 2'b00;
    repeat (3) @(negedge clk);
    check(href, 1, "R2 held after mode off");
    field(1'b0);
    check(href, 0, "R2 new field decision");
  endtask

  task automatic t_prog_all();
    reset_dut();
    progressive = 1'b1;
    field_mode = 2'b11;
    slot_sel = 6'b000100;
    for (int f = 0; f < 5; f++) begin
      field(1'b1);
      check(href, 1, "R4 every frame");
    end
  endtask

  task automatic t_prog_slot();
    reset_dut();
    progressive = 1'b1;
    field_mode = 2'b01;
    slot_sel = 6'b000010;
    for (int f = 0; f < 9; f++) begin
      field(1'b1);
      check(href, int'(f % 4 == 0), "R5 divide by 4");
    end
    reset_dut();
    field_mode = 2'b10;
    slot_sel = 6'b100000;
    for (int f = 0; f < 65; f++) begin
      field(1'b1);
      if (f == 0 || f == 1 || f == 63 || f == 64)
        check(href, int'(f % 64 == 0), "R5 divide by 64");
    end
  endtask

  task automatic t_invalid();
    reset_dut();
    progressive = 1'b1;
    field_mode = 2'b01;
    slot_sel = 6'b000011;
    for (int f = 0; f < 5; f++) begin
      field(1'b1);
      check(href, int'(f % 2 == 0), "R6 two bits set");
    end
    reset_dut();
    slot_sel = 6'b000000;
    for (int f = 0; f < 4; f++) begin
      field(1'b1);
      check(href, int'(f % 2 == 0), "R6 zero value");
    end
  endtask

  task automatic t_single();
    reset_dut();
    progressive = 1'b0;
    field_mode = 2'b00;
    single_req = 1'b1;
    field(1'b1);
    check(href, 1, "R7 first odd field");
    check(clr_seen, 0, "R9 no early clr");
    field(1'b0);
    check(href, 1, "R7 second even field");
    field(1'b1);
    check(href, 0, "R7 closed after pair");
    check(clr_seen, 1, "R9 clr at end of pair");
    field(1'b0);
    field(1'b1);
    check(href, 0, "R7 no re-open");
  endtask

  task automatic t_wait_odd();
    reset_dut();
    field_mode = 2'b00;
    progressive = 1'b0;
    single_req = 1'b1;
    field(1'b0);
    check(href, 0, "R8 even field waits");
    field(1'b1);
    check(href, 1, "R8 starts on odd");
    single_req = 1'b0;
    field(1'b0);
    check(href, 1, "R10 second field kept");
    field(1'b1);
    check(href, 0, "R10 closed");
    check(clr_seen, 1, "R10 clr still issued");
  endtask

  task automatic t_ignored();
    reset_dut();
    progressive = 1'b0;
    field_mode = 2'b01;
    single_req = 1'b1;
    for (int f = 0; f < 4; f++) begin
      field(f % 2 == 0);
      check(href, int'(f % 2 == 0), "R11 follows mode");
      check(clr_seen, 0, "R11 no clr");
    end
    single_req = 1'b0;
  endtask

  task automatic t_window();
    reset_dut();
    progressive = 1'b0;
    field_mode = 2'b11;
    field(1'b1);
    href_win = 1'b0;
    @(negedge clk);
    check(href, 0, "R12 window low");
    check(field_en, 1, "R12 enable held");
    href_win = 1'b1;
    @(negedge clk);
    check(href, 1, "R12 window high");
  endtask

  initial begin
    t_reset();
    t_interlace();
    t_hold();
    t_prog_all();
    t_prog_slot();
    t_invalid();
    t_single();
    t_wait_odd();
    t_ignored();
    t_window();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule